// File: doc/BRIEF.md
# SPI Controller with Status Flags

This block is a byte-wide serial peripheral engine that sits on a small 8-bit processor bus. It can act as the clock-driving master or as a clocked slave. Software sees three registers. A control register selects interrupt enable, core enable and master role. A status register holds three flags: byte done, write collision and mode fault. A data register accepts the byte to send, and reading it returns the last byte received. Transfers are always eight bits, most significant bit first, in clock mode 0: the clock idles low, data is sampled on the rising edge and the outgoing line changes on the falling edge. The master clock half period is a parameter, counted in system clocks.

Each flag is cleared by a two-step handshake. Software first reads the status register while the flag is set. It then accesses the data register, or for a mode fault it writes the control register. Until the first step has happened for a pending byte-done flag, writes to the data register are dropped. The receive side holds one finished byte in a buffer while the shifter takes in the next byte. The transmit side has no buffer, so a write made while a byte is moving is rejected and flagged.

Top module: `sspi_core`

## Requirements
- R1: After a synchronous active-low reset the control, status and data registers all read 0x00, `irq` is low and `sclk_o` is low.
- R2: Register addresses are 0 for control, 1 for status, 2 for data, and address 3 reads 0x00. Control bits are: bit 7 interrupt enable, bit 6 core enable, bit 4 master select, all other bits read 0. Status bits are: bit 7 byte done, bit 6 write collision, bit 4 mode fault, all other bits read 0.
- R3: In master mode, a data write with enable and master set sends the byte MSB first on `sdo` over 8 clock pulses on `sclk_o`. `sclk_o` idles low and each high and low phase lasts DIV_HALF system clocks. `sdi` is sampled on each rising edge of `sclk_o`.
- R4: When the eighth bit has shifted, the byte-done flag sets and the received byte becomes readable at the data address. This holds in both master and slave modes.
- R5: `irq` is high exactly while byte done is set and interrupt enable is 1. With interrupt enable 0 it stays low.
- R6: Byte done clears only after a status read that sees it set, followed by a read or write of the data register. A data read without that prior status read leaves it set.
- R7: While byte done is set and no status read has seen it, a data write is ignored. It starts no transfer and sets no collision flag.
- R8: A data write accepted while a byte is shifting sets write collision and leaves the shifting byte unchanged. Write collision clears after a status read that sees it set, followed by a data-register access.
- R9: With enable and master set, a low level on `ss_n_i` sets mode fault and clears the enable and master bits. The clock on `sclk_o` stops.
- R10: Mode fault clears only after a status read that sees it set, followed by a control write. A control write without that prior read leaves it set.
- R11: In slave mode, shifting happens only on edges of `sclk_i` while `ss_n_i` is low. A data write loads the byte to send and produces no pulses on `sclk_o`.
- R12: If a byte completes while byte done is still set, the new byte is dropped and the data register keeps the earlier byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; read side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | Interrupt request |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low select; in master mode a low level is a fault |
| sdi | input | 1 | Serial data in (from the slave in master mode, from the master in slave mode) |
| sdo | output | 1 | Serial data out |

## Verification
The embedded assertions check these rules on every cycle:
- the clock is idle whenever no byte is in flight, and the done strobe is a single pulse;
- a done pulse always sets byte done, and raises `irq` when interrupt enable is set;
- byte done and mode fault never drop without the access that clears them;
- a collision always raises its flag, and a fault always raises mode fault and clears the role bits;
- a blocked write never starts the shifter;
- an overrun leaves the receive buffer untouched.

Other behaviour depends on the bench's own scenarios. This covers the bit order and phase timing on the serial lines, and the contents of the received bytes. It also covers whether the arming read must come first in each clearing handshake, slave shifting that depends on the select line, and which byte survives an overrun.

// File: rtl/sspi_pkg.sv
// Package: shared register selects, bit positions and the control record
// for the serial peripheral core. Assumes an 8-bit register view.
package sspi_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // control register bit positions
    localparam int CTL_IE   = 7;
    localparam int CTL_EN   = 6;
    localparam int CTL_MSTR = 4;

    // status register bit positions
    localparam int ST_DONE  = 7;
    localparam int ST_COLL  = 6;
    localparam int ST_FAULT = 4;

    typedef struct packed {
        logic ie;
        logic en;
        logic mstr;
    } ctrl_t;

endpackage

// File: rtl/sspi_sync.sv
// Module: multi-stage synchronizer for asynchronous pin inputs.
// Assumes each bit is independent; reset value is a parameter so idle
// levels (select high, clock low) appear from the first cycle.
module sspi_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Purpose: shift the pin sample through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sspi_shift.sv
// Module: byte shift engine, mode 0, MSB first.
// Master role: generates the serial clock from a half-period divider.
// Slave role: follows synchronized edge strobes while selected.
// Assumes start/load are only given when the engine is idle.
module sspi_shift #(
    parameter int DW       = 8,
    parameter int DIV_HALF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mstr,
    input  logic          start,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          m_sdi,
    input  logic          s_sel,
    input  logic          s_rise,
    input  logic          s_fall,
    input  logic          s_sdi,
    output logic          busy,
    output logic          done,
    output logic          sck,
    output logic [DW-1:0] shreg_o,
    output logic          sdo
);

    localparam int            CW       = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int            BW       = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(DIV_HALF - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

    logic [DW-1:0] sh;
    logic [CW-1:0] div;
    logic [BW-1:0] nbit;
    logic          samp;
    logic          sck_q;

    // Purpose: run the master divider or follow slave edges, shifting one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sh    <= '0;
            div   <= '0;
            nbit  <= '0;
            samp  <= 1'b0;
            sck_q <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (mstr) begin
                if (start) begin
                    sh    <= load_data;
                    busy  <= 1'b1;
                    div   <= '0;
                    sck_q <= 1'b0;
                    nbit  <= '0;
                end else if (busy) begin
                    if (div == DIV_LAST) begin
                        div <= '0;
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                            samp  <= m_sdi;
                        end else begin
                            sck_q <= 1'b0;
                            sh    <= {sh[DW-2:0], samp};
                            nbit  <= nbit + 1'b1;
                            if (nbit == BIT_LAST) begin
                                busy <= 1'b0;
                                done <= 1'b1;
                            end
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end
            end else begin
                sck_q <= 1'b0;
                div   <= '0;
                if (!s_sel) begin
                    nbit <= '0;
                    busy <= 1'b0;
                    if (load) sh <= load_data;
                end else begin
                    if (load && !busy) sh <= load_data;
                    if (s_rise) begin
                        samp <= s_sdi;
                        busy <= 1'b1;
                    end
                    if (s_fall && busy) begin
                        sh   <= {sh[DW-2:0], samp};
                        nbit <= nbit + 1'b1;
                        if (nbit == BIT_LAST) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign sck     = sck_q;
    assign sdo     = sh[DW-1];
    assign shreg_o = sh;

    // R3
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_q);

    // R4
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sspi_flags.sv
// Module: status flags with two-step clearing.
// Each flag arms on a status read that sees it set; the armed flag clears
// on its second access (data access, or control write for the fault).
// A new setting event in the same cycle as a clear wins.
module sspi_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic ctrl_wr,
    input  logic xfer_done,
    input  logic collide,
    input  logic fault,
    output logic done_f,
    output logic done_arm,
    output logic coll_f,
    output logic fault_f
);

    logic coll_arm;
    logic fault_arm;
    logic done_clr;
    logic coll_clr;
    logic fault_clr;

    assign done_clr  = done_arm  & data_acc;
    assign coll_clr  = coll_arm  & data_acc;
    assign fault_clr = fault_arm & ctrl_wr;

    // Purpose: byte-done flag and its arming bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_f   <= 1'b0;
            done_arm <= 1'b0;
        end else begin
            if (xfer_done)     done_f <= 1'b1;
            else if (done_clr) done_f <= 1'b0;
            if (done_clr)                done_arm <= 1'b0;
            else if (stat_rd && done_f)  done_arm <= 1'b1;
        end
    end

    // Purpose: write-collision flag and its arming bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_f   <= 1'b0;
            coll_arm <= 1'b0;
        end else begin
            if (collide)       coll_f <= 1'b1;
            else if (coll_clr) coll_f <= 1'b0;
            if (coll_clr)                coll_arm <= 1'b0;
            else if (stat_rd && coll_f)  coll_arm <= 1'b1;
        end
    end

    // Purpose: mode-fault flag and its arming bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_f   <= 1'b0;
            fault_arm <= 1'b0;
        end else begin
            if (fault)          fault_f <= 1'b1;
            else if (fault_clr) fault_f <= 1'b0;
            if (fault_clr)               fault_arm <= 1'b0;
            else if (stat_rd && fault_f) fault_arm <= 1'b1;
        end
    end

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_f && !data_acc |=> done_f);

    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_f && !ctrl_wr |=> fault_f);

    // R4
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> done_f);

endmodule

// File: rtl/sspi_core.sv
// Module: serial peripheral core top. Decodes the three-register bus view,
// holds control bits and the receive buffer, gates data writes by the flag
// handshake, and detects master-mode select faults.
// Assumes one-cycle bus strobes and an 8-bit register layout.
module sspi_core
    import sspi_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DIV_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq,
    output logic          sclk_o,
    input  logic          sclk_i,
    input  logic          ss_n_i,
    input  logic          sdi,
    output logic          sdo
);

    localparam int PW = 3;

    reg_sel_e      sel;
    logic          stat_rd, data_rd, data_wr, ctrl_wr, data_acc;
    ctrl_t         ctl;
    logic [DW-1:0] rx;
    logic [PW-1:0] pin_s;
    logic          sclk_s, ss_n_s, sdi_s, sclk_prev;
    logic          s_rise, s_fall;
    logic          fault, wr_ok, collide, start, load;
    logic          busy, done;
    logic [DW-1:0] shreg;
    logic          done_f, done_arm, coll_f, fault_f;

    assign sel      = reg_sel_e'(bus_addr);
    assign stat_rd  = bus_rd & (sel == SEL_STAT);
    assign data_rd  = bus_rd & (sel == SEL_DATA);
    assign data_wr  = bus_wr & (sel == SEL_DATA);
    assign ctrl_wr  = bus_wr & (sel == SEL_CTRL);
    assign data_acc = data_rd | data_wr;

    sspi_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_i, ss_n_i, sdi}),
        .q     (pin_s)
    );
    assign {sclk_s, ss_n_s, sdi_s} = pin_s;

    // Purpose: remember last synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end
    assign s_rise = sclk_s & ~sclk_prev;
    assign s_fall = ~sclk_s & sclk_prev;

    assign fault   = ctl.en & ctl.mstr & ~ss_n_s;
    assign wr_ok   = data_wr & (~done_f | done_arm);
    assign collide = wr_ok & busy;
    assign start   = wr_ok & ~busy & ctl.en & ctl.mstr & ~fault;
    assign load    = wr_ok & ~busy & ctl.en & ~ctl.mstr;

    // Purpose: control register; a fault drops enable and master role.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else begin
            if (ctrl_wr) ctl.ie <= bus_wdata[CTL_IE];
            if (fault) begin
                ctl.en   <= 1'b0;
                ctl.mstr <= 1'b0;
            end else if (ctrl_wr) begin
                ctl.en   <= bus_wdata[CTL_EN];
                ctl.mstr <= bus_wdata[CTL_MSTR];
            end
        end
    end

    // Purpose: receive buffer; keeps the older byte on overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) rx <= '0;
        else if (done && (!done_f || (done_arm && data_acc))) rx <= shreg;
    end

    sspi_shift #(.DW(DW), .DIV_HALF(DIV_HALF)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl.en),
        .mstr      (ctl.mstr),
        .start     (start),
        .load      (load),
        .load_data (bus_wdata),
        .m_sdi     (sdi),
        .s_sel     (~ss_n_s),
        .s_rise    (s_rise),
        .s_fall    (s_fall),
        .s_sdi     (sdi_s),
        .busy      (busy),
        .done      (done),
        .sck       (sclk_o),
        .shreg_o   (shreg),
        .sdo       (sdo)
    );

    sspi_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_rd   (stat_rd),
        .data_acc  (data_acc),
        .ctrl_wr   (ctrl_wr),
        .xfer_done (done),
        .collide   (collide),
        .fault     (fault),
        .done_f    (done_f),
        .done_arm  (done_arm),
        .coll_f    (coll_f),
        .fault_f   (fault_f)
    );

    assign irq = done_f & ctl.ie;

    // Purpose: register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                bus_rdata[CTL_IE]   = ctl.ie;
                bus_rdata[CTL_EN]   = ctl.en;
                bus_rdata[CTL_MSTR] = ctl.mstr;
            end
            SEL_STAT: begin
                bus_rdata[ST_DONE]  = done_f;
                bus_rdata[ST_COLL]  = coll_f;
                bus_rdata[ST_FAULT] = fault_f;
            end
            SEL_DATA: bus_rdata = rx;
            default:  bus_rdata = '0;
        endcase
    end

    // R5
    irq_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && ctl.ie |=> irq);

    // R9
    fault_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault_f && !ctl.en && !ctl.mstr);

    // R8
    collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> coll_f);

    // R7
    blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && done_f && !done_arm && !busy && ctl.mstr |=> !busy);

    // R12
    overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_f && !data_acc |=> $stable(rx));

endmodule

// File: tb/sim_sspi_core.sv
`timescale 1ns/1ps
module sim_sspi_core;

    localparam int DIVH = 4;
    localparam int SH   = 20;
    localparam logic [15:0] VEC [6] = '{16'hA53C, 16'h00FF, 16'hFF00,
                                        16'h8001, 16'h7E81, 16'h1234};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, sclk_o, sdo, sdi;
    logic       sclk_in = 1'b0, ss_n = 1'b1;
    logic       tb_slave = 1'b0, s_bit = 1'b0;

    int checks = 0, fails = 0;

    // bench-side slave model for master transfers
    logic [7:0] slv_byte = 8'h00;
    int         fall_cnt = 0, rise_cnt = 0, base = 0;
    logic [7:0] mon = 8'h00;
    time        t_rise = 0, hi_w = 0;

    always #2.5 clk = ~clk;

    sspi_core #(.DW(8), .DIV_HALF(DIVH), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .sclk_o(sclk_o),
        .sclk_i(sclk_in), .ss_n_i(ss_n), .sdi(sdi), .sdo(sdo)
    );

    always @(posedge sclk_o) begin
        mon      <= {mon[6:0], sdo};
        rise_cnt <= rise_cnt + 1;
        t_rise   <= $time;
    end
    always @(negedge sclk_o) begin
        fall_cnt <= fall_cnt + 1;
        hi_w     <= $time - t_rise;
    end

    always_comb begin
        int k;
        k = fall_cnt - base;
        if (tb_slave)              sdi = s_bit;
        else if (k >= 0 && k < 8)  sdi = slv_byte[7-k];
        else                       sdi = 1'b0;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic br(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input string req);
        int t;
        t = 0;
        while (!irq && t < 400) begin @(negedge clk); t++; end
        chk(req, {7'd0, irq}, 8'h01);
    endtask

    task automatic master_go(input logic [7:0] tx, input logic [7:0] reply);
        slv_byte = reply;
        base     = fall_cnt;
        bw(2'd2, tx);
    endtask

    task automatic slave_xfer(input logic [7:0] b, output logic [7:0] seen);
        ss_n = 1'b0;
        s_bit = b[7];
        seen = 8'h00;
        idle(10);
        for (int i = 7; i >= 0; i--) begin
            idle(SH);
            sclk_in = 1'b1;
            seen = {seen[6:0], sdo};
            idle(SH);
            sclk_in = 1'b0;
            if (i > 0) s_bit = b[i-1];
        end
        idle(10);
        ss_n = 1'b1;
        idle(5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int rc;
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        br(2'd1, v); chk("R1 status", v, 8'h00);
        br(2'd0, v); chk("R1 control", v, 8'h00);
        br(2'd2, v); chk("R1 data", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 sclk_o", {7'd0, sclk_o}, 8'h00);
        br(2'd3, v); chk("R2 unused address", v, 8'h00);

        // R2 control layout: ie, enable, master
        bw(2'd0, 8'hFF);
        br(2'd0, v); chk("R2 control bits", v, 8'hD0);

        // table of master transfers: {tx, slave reply}
        for (int i = 0; i < 6; i++) begin
            master_go(VEC[i][15:8], VEC[i][7:0]);
            wait_irq("R4 master done irq");
            br(2'd1, v); chk("R2 status done", v, 8'h80);
            chk("R3 bits on sdo", mon, VEC[i][15:8]);
            br(2'd2, v); chk("R4 received byte", v, VEC[i][7:0]);
            chk("R6 cleared irq", {7'd0, irq}, 8'h00);
        end
        chk("R3 high phase ns", 8'(hi_w), 8'(DIVH * 5));
        chk("R3 sclk idle", {7'd0, sclk_o}, 8'h00);

        // R6 data read without arming read keeps flag
        master_go(8'h5A, 8'hC3);
        wait_irq("R6 setup");
        br(2'd2, v);
        chk("R6 flag kept", {7'd0, irq}, 8'h01);

        // R7 data write while unarmed is ignored
        rc = rise_cnt;
        bw(2'd2, 8'h55);
        idle(100);
        chk("R7 no clocks", 8'(rise_cnt - rc), 8'h00);
        br(2'd1, v); chk("R7 no collision", v, 8'h80);
        br(2'd2, v); chk("R6 two-step clear", {7'd0, irq}, 8'h00);

        // R8 write collision
        master_go(8'hA5, 8'h0F);
        idle(10);
        bw(2'd2, 8'h3C);
        wait_irq("R8 setup");
        br(2'd1, v); chk("R8 collision flag", v, 8'hC0);
        chk("R8 shifting byte intact", mon, 8'hA5);
        br(2'd2, v); chk("R8 rx intact", v, 8'h0F);
        br(2'd1, v); chk("R8 flags cleared", v, 8'h00);

        // R5 interrupt disabled
        bw(2'd0, 8'h50);
        master_go(8'h81, 8'h18);
        idle(16 * DIVH + 20);
        chk("R5 irq masked", {7'd0, irq}, 8'h00);
        br(2'd1, v); chk("R5 done still set", v, 8'h80);
        br(2'd2, v);

        // R9 mode fault
        bw(2'd0, 8'hD0);
        ss_n = 1'b0;
        idle(10);
        ss_n = 1'b1;
        idle(5);
        br(2'd0, v); chk("R9 role bits cleared", v, 8'h80);
        chk("R9 sclk stopped", {7'd0, sclk_o}, 8'h00);
        bw(2'd0, 8'h80);
        br(2'd1, v); chk("R10 fault kept without read", v, 8'h10);
        bw(2'd0, 8'h00);
        br(2'd1, v); chk("R10 fault cleared", v, 8'h00);

        // R11 slave mode
        tb_slave = 1'b1;
        bw(2'd0, 8'h40);
        rc = rise_cnt;
        bw(2'd2, 8'h96);
        idle(50);
        chk("R11 no master clock", 8'(rise_cnt - rc), 8'h00);
        for (int i = 0; i < 8; i++) begin
            idle(SH); sclk_in = 1'b1; idle(SH); sclk_in = 1'b0;
        end
        idle(10);
        br(2'd1, v); chk("R11 unselected ignored", v, 8'h00);
        slave_xfer(8'h3B, v);
        chk("R11 slave sent byte", v, 8'h96);

        // R12 overrun: second byte without clearing
        slave_xfer(8'hE1, v);
        br(2'd1, v); chk("R4 slave done", v, 8'h80);
        br(2'd2, v); chk("R12 earlier byte kept", v, 8'h3B);
        br(2'd1, v); chk("R6 slave clear", v, 8'h00);
        slave_xfer(8'h5A, v);
        br(2'd1, v);
        br(2'd2, v); chk("R4 slave received", v, 8'h5A);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule